// File: doc/BRIEF.md
# Serial Receive DMA Engine

This block moves received serial bytes into memory. It has a byte-wide write master port. Software first sets a destination pointer. It then writes a transfer length, and that write starts the transfer. The engine looks at how many bytes the receive FIFO already holds when the transfer starts. It copies the smaller of that count and the length out of the FIFO, in FIFO order. Any shortfall becomes the pending size. The pending size is then filled straight from the live receive stream, one accepted byte at a time.

The current pointer and the remaining pending size are visible on output ports, so a register block can return them on reads. Completion is reported when the pending size is zero and the interrupt enable is set. As a result, an engine with no transfer running reads as complete. Rewriting the pointer aborts whatever transfer is running.

The block does not contain register decoding or the FIFO storage. It reaches those through strobes, a count, a show-ahead data word and a pop strobe.

Top module: `rxdma_engine`

## Requirements
- R1: A pointer write (`cfg_addr_we`) loads `cur_ptr` with `cfg_addr_wdata`, forces `pend_size` to 0 and stops any drain in progress. No further memory writes follow until a new length write.
- R2: A non-zero length write, made while no drain is in progress, snapshots `fifo_count`. The drain amount is min(count, length), and `pend_size` becomes length minus that amount. The new `pend_size` is visible in the cycle after the write.
- R3: Drained bytes are written to memory in FIFO order at `cur_ptr`, `cur_ptr`+1, and so on. `fifo_pop` pulses only in a cycle where the memory write is accepted (`mem_valid` and `mem_ready` both 1). Exactly the drain amount is popped.
- R4: Live bytes are accepted only after the drain has finished and while `pend_size` is non-zero. Each accepted byte is written at `cur_ptr`, after which `cur_ptr` increments and `pend_size` decrements. At all other times `rx_ready` is 0.
- R5: While `mem_ready` is 0, a drain write stays presented: `mem_valid` stays 1 and `mem_addr` stays unchanged.
- R6: A length write made while a drain is still in progress is ignored. It changes neither `pend_size` nor the number of bytes written.
- R7: A length write of 0 changes neither `cur_ptr` nor `pend_size`, and it produces no memory write.
- R8: `done_irq` is 1 exactly when `irq_en` is 1 and `pend_size` is 0.
- R9: After reset, `cur_ptr` is 0, `pend_size` is 0 and `mem_valid` is 0.
- R10: When a pointer write and a length write arrive in the same cycle, the pointer write wins and the length write is ignored.
- R11: `cur_ptr` advances modulo 2^AW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_addr_we | input | 1 | Pointer write strobe |
| cfg_addr_wdata | input | AW | New destination pointer |
| cfg_len_we | input | 1 | Length write strobe, starts a transfer |
| cfg_len_wdata | input | LW | Transfer length in bytes |
| irq_en | input | 1 | Completion interrupt enable |
| fifo_count | input | CW | Bytes currently held in the receive FIFO |
| fifo_rdata | input | 8 | Head byte of the FIFO (show-ahead) |
| fifo_pop | output | 1 | Removes the FIFO head |
| rx_valid | input | 1 | Live receive byte offered |
| rx_data | input | 8 | Live receive byte |
| rx_ready | output | 1 | Live byte taken this cycle when rx_valid is 1 |
| mem_valid | output | 1 | Memory byte write request |
| mem_addr | output | AW | Memory write address |
| mem_data | output | 8 | Memory write data |
| mem_ready | input | 1 | Memory accepts the write |
| cur_ptr | output | AW | Live destination pointer |
| pend_size | output | LW | Remaining bytes to take from the live stream |
| done_irq | output | 1 | Completion request |

## Verification
Pointer and length writes take effect at the clock edge that samples them, so `cur_ptr` and `pend_size` are read one clock after the strobe. `done_irq` follows `pend_size` in the same cycle. The memory port and the handshake outputs are combinational from state and inputs. The bench therefore records a handshake shortly before the edge that completes it and advances its FIFO and stream models only after that edge. Every check reads the outputs one nanosecond after a rising edge, so no check samples a value while it is changing.

// File: rtl/rxdma_pkg.sv
// Shared types for the receive DMA engine.
// Assumes nothing beyond a plain SystemVerilog compile.
package rxdma_pkg;

    // Which source feeds the memory write port this cycle
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_FIFO = 2'd1,
        SRC_LIVE = 2'd2
    } rxdma_src_e;

endpackage

// File: rtl/rxdma_split.sv
// Splits a requested length into the part taken from the FIFO and
// the part left pending for the live stream.
// Assumes the FIFO count is sampled in the same cycle as the length write.
module rxdma_split #(
    parameter int LW = 8,
    parameter int CW = 5
) (
    input  logic [LW-1:0] len_val,
    input  logic [CW-1:0] fifo_count,
    output logic [LW-1:0] drain_n,
    output logic [LW-1:0] pend_n
);
    localparam int SW = (LW > CW) ? LW : CW;

    logic [SW-1:0] len_ext;
    logic [SW-1:0] cnt_ext;

    // Widen both operands to a common width before comparing
    always_comb begin
        len_ext = SW'(len_val);
        cnt_ext = SW'(fifo_count);
    end

    // Take the whole FIFO when it is short, else exactly the length
    always_comb begin
        if (cnt_ext < len_ext) begin
            drain_n = cnt_ext[LW-1:0];
            pend_n  = len_val - cnt_ext[LW-1:0];
        end else begin
            drain_n = len_val;
            pend_n  = '0;
        end
    end
endmodule

// File: rtl/rxdma_ptr.sv
// Destination pointer register: loads on a pointer write and steps by
// one on each accepted memory write. Wraps modulo 2^AW.
// Assumes a load and an increment never need to be combined.
module rxdma_ptr #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step,
    output logic [AW-1:0] ptr
);
    // Pointer update; a load takes priority over a step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (load) begin
            ptr <= load_val;
        end else if (step) begin
            ptr <= ptr + AW'(1);
        end
    end
endmodule

// File: rtl/rxdma_ctrl.sv
// Transfer control: holds the drain and pending counters, selects the
// byte source and forms the memory request and handshake.
// Assumes fifo_count is stable during the cycle of a length write.
module rxdma_ctrl
    import rxdma_pkg::*;
#(
    parameter int LW = 8,
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          addr_we,
    input  logic          len_we,
    input  logic [LW-1:0] len_val,
    input  logic [CW-1:0] fifo_count,
    input  logic          rx_valid,
    input  logic          mem_ready,
    output rxdma_src_e    src,
    output logic          req,
    output logic          fire,
    output logic [LW-1:0] pend
);
    logic [LW-1:0] drain_left;
    logic [LW-1:0] drain_n;
    logic [LW-1:0] pend_n;
    logic          busy;
    logic          start;

    rxdma_split #(.LW(LW), .CW(CW)) u_split (
        .len_val    (len_val),
        .fifo_count (fifo_count),
        .drain_n    (drain_n),
        .pend_n     (pend_n)
    );

    // A start needs a non-zero length, no drain running and no pointer write
    always_comb begin
        busy  = (drain_left != '0);
        start = len_we && !addr_we && !busy && (len_val != '0);
    end

    // Source choice: drain first, live stream only when nothing else is written
    always_comb begin
        if (addr_we) begin
            src = SRC_NONE;
        end else if (busy) begin
            src = SRC_FIFO;
        end else if ((pend != '0) && !len_we) begin
            src = SRC_LIVE;
        end else begin
            src = SRC_NONE;
        end
    end

    // Memory request and its acceptance
    always_comb begin
        req  = (src == SRC_FIFO) || ((src == SRC_LIVE) && rx_valid);
        fire = req && mem_ready;
    end

    // Counter update: cancel, start, or count down on accepted writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drain_left <= '0;
            pend       <= '0;
        end else if (addr_we) begin
            drain_left <= '0;
            pend       <= '0;
        end else if (start) begin
            drain_left <= drain_n;
            pend       <= pend_n;
        end else if (fire) begin
            if (src == SRC_FIFO) begin
                drain_left <= drain_left - LW'(1);
            end else begin
                pend <= pend - LW'(1);
            end
        end
    end
endmodule

// File: rtl/rxdma_engine.sv
// Top of the serial receive DMA engine. Drains the receive FIFO, then
// streams live bytes into memory through a byte write port.
// Assumes fifo_rdata shows the FIFO head whenever fifo_count is non-zero.
module rxdma_engine
    import rxdma_pkg::*;
#(
    parameter int AW = 16,
    parameter int LW = 8,
    parameter int CW = 5,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_addr_we,
    input  logic [AW-1:0] cfg_addr_wdata,
    input  logic          cfg_len_we,
    input  logic [LW-1:0] cfg_len_wdata,
    input  logic          irq_en,
    input  logic [CW-1:0] fifo_count,
    input  logic [DW-1:0] fifo_rdata,
    output logic          fifo_pop,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_data,
    output logic          rx_ready,
    output logic          mem_valid,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_data,
    input  logic          mem_ready,
    output logic [AW-1:0] cur_ptr,
    output logic [LW-1:0] pend_size,
    output logic          done_irq
);
    rxdma_src_e src;
    logic       fire;

    rxdma_ctrl #(.LW(LW), .CW(CW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_we    (cfg_addr_we),
        .len_we     (cfg_len_we),
        .len_val    (cfg_len_wdata),
        .fifo_count (fifo_count),
        .rx_valid   (rx_valid),
        .mem_ready  (mem_ready),
        .src        (src),
        .req        (mem_valid),
        .fire       (fire),
        .pend       (pend_size)
    );

    rxdma_ptr #(.AW(AW)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cfg_addr_we),
        .load_val (cfg_addr_wdata),
        .step     (fire),
        .ptr      (cur_ptr)
    );

    // Memory port data and address from the selected source
    always_comb begin
        mem_addr = cur_ptr;
        mem_data = (src == SRC_FIFO) ? fifo_rdata : rx_data;
    end

    // Handshakes back to the FIFO and the live stream
    always_comb begin
        fifo_pop = fire && (src == SRC_FIFO);
        rx_ready = (src == SRC_LIVE) && mem_ready;
    end

    // Completion request: enabled and nothing pending
    always_comb begin
        done_irq = irq_en && (pend_size == '0);
    end
endmodule

// File: rtl/rxdma_engine_chk.sv
// Property checker for the receive DMA engine, bound to its top module.
// Assumes it observes only the top module's ports.
module rxdma_engine_chk #(
    parameter int AW = 16,
    parameter int LW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_addr_we,
    input logic [AW-1:0] cfg_addr_wdata,
    input logic          cfg_len_we,
    input logic [LW-1:0] cfg_len_wdata,
    input logic          irq_en,
    input logic          fifo_pop,
    input logic          rx_valid,
    input logic          rx_ready,
    input logic          mem_valid,
    input logic [AW-1:0] mem_addr,
    input logic          mem_ready,
    input logic [AW-1:0] cur_ptr,
    input logic [LW-1:0] pend_size,
    input logic          done_irq
);
    // R1
    cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_addr_we |=> (pend_size == '0) && (cur_ptr == $past(cfg_addr_wdata)));

    // R3
    pop_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> (mem_valid && mem_ready));

    // R4
    live_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ready) |-> (mem_valid && mem_ready && !fifo_pop && (pend_size != '0)));

    // R4
    pend_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ready && !cfg_addr_we && !cfg_len_we)
        |=> (pend_size == $past(pend_size) - LW'(1)) && (cur_ptr == $past(cur_ptr) + AW'(1)));

    // R5
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready && !cfg_addr_we) |=> $stable(mem_addr));

    // R7
    zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_len_we && (cfg_len_wdata == '0) && !cfg_addr_we && !(mem_valid && mem_ready))
        |=> $stable(cur_ptr) && $stable(pend_size));

    // R8
    irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq == (irq_en && (pend_size == '0)));
endmodule

bind rxdma_engine rxdma_engine_chk #(.AW(AW), .LW(LW)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_addr_we    (cfg_addr_we),
    .cfg_addr_wdata (cfg_addr_wdata),
    .cfg_len_we     (cfg_len_we),
    .cfg_len_wdata  (cfg_len_wdata),
    .irq_en         (irq_en),
    .fifo_pop       (fifo_pop),
    .rx_valid       (rx_valid),
    .rx_ready       (rx_ready),
    .mem_valid      (mem_valid),
    .mem_addr       (mem_addr),
    .mem_ready      (mem_ready),
    .cur_ptr        (cur_ptr),
    .pend_size      (pend_size),
    .done_irq       (done_irq)
);

// File: tb/rxdma_engine_bench.sv
`timescale 1ns/1ps
// Self-checking bench: sweeps FIFO fill and length, plus targeted cases.
module rxdma_engine_bench;
    localparam int AW = 16;
    localparam int LW = 8;
    localparam int CW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_addr_we = 1'b0;
    logic [AW-1:0] cfg_addr_wdata = '0;
    logic          cfg_len_we = 1'b0;
    logic [LW-1:0] cfg_len_wdata = '0;
    logic          irq_en = 1'b1;
    logic [CW-1:0] fifo_count = '0;
    logic [7:0]    fifo_rdata = '0;
    logic          fifo_pop;
    logic          rx_valid = 1'b0;
    logic [7:0]    rx_data = '0;
    logic          rx_ready;
    logic          mem_valid;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_data;
    logic          mem_ready = 1'b0;
    logic [AW-1:0] cur_ptr;
    logic [LW-1:0] pend_size;
    logic          done_irq;

    rxdma_engine #(.AW(AW), .LW(LW), .CW(CW), .DW(8)) u_rxdma_engine (
        .clk(clk), .rst_n(rst_n),
        .cfg_addr_we(cfg_addr_we), .cfg_addr_wdata(cfg_addr_wdata),
        .cfg_len_we(cfg_len_we), .cfg_len_wdata(cfg_len_wdata),
        .irq_en(irq_en), .fifo_count(fifo_count), .fifo_rdata(fifo_rdata),
        .fifo_pop(fifo_pop), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_ready(rx_ready), .mem_valid(mem_valid), .mem_addr(mem_addr),
        .mem_data(mem_data), .mem_ready(mem_ready), .cur_ptr(cur_ptr),
        .pend_size(pend_size), .done_irq(done_irq)
    );

    always #2.5 clk = ~clk;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // bench models
    logic [7:0]    fifo_mem [0:63];
    logic [7:0]    s_mem [0:63];
    logic [AW-1:0] log_a [0:63];
    logic [7:0]    log_d [0:63];
    int head, fcnt, s_idx, s_n, nlog, cyc, rdy_mode;
    bit req_aw, req_lw;
    logic [AW-1:0] req_av;
    logic [LW-1:0] req_lv;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One clock: drive at the falling edge, record handshakes before the
    // rising edge, advance the models after it, settle for reading.
    task automatic tick();
        bit popd, took;
        @(negedge clk);
        cfg_addr_we    = req_aw; cfg_addr_wdata = req_av;
        cfg_len_we     = req_lw; cfg_len_wdata  = req_lv;
        req_aw = 0; req_lw = 0;
        mem_ready  = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? (cyc % 3 != 1) : 1'b0;
        fifo_count = CW'(fcnt);
        fifo_rdata = fifo_mem[head];
        rx_valid   = (s_idx < s_n);
        rx_data    = s_mem[s_idx];
        #1;
        popd = fifo_pop;
        took = rx_valid && rx_ready;
        if (mem_valid && mem_ready && nlog < 64) begin
            log_a[nlog] = mem_addr; log_d[nlog] = mem_data; nlog++;
        end
        @(posedge clk);
        cyc++;
        if (popd) begin head++; fcnt--; end
        if (took) s_idx++;
        #1;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic prep(input int k, input int mode);
        rdy_mode = mode; head = 0; fcnt = k; s_idx = 0; s_n = 0; nlog = 0;
        for (int i = 0; i < 64; i++) begin
            fifo_mem[i] = 8'(8'h40 + i * 3 + k);
            s_mem[i]    = 8'(8'hA0 + i);
        end
    endtask

    task automatic wr_addr(input logic [AW-1:0] a);
        req_aw = 1; req_av = a; tick();
    endtask

    task automatic wr_len(input logic [LW-1:0] l);
        req_lw = 1; req_lv = l; tick();
    endtask

    task automatic run_case(input logic [AW-1:0] addr, input int len, input int k, input int mode);
        int dr, pe, bad, guard;
        prep(k, mode);
        wr_addr(addr);
        chk(cur_ptr == addr, "R1", "pointer load", cur_ptr, addr);
        chk(pend_size == 0, "R1", "pend after pointer write", pend_size, 0);
        dr = (k < len) ? k : len;
        pe = len - dr;
        s_n = pe;
        wr_len(LW'(len));
        chk(pend_size == LW'(pe), "R2", "pend after start", pend_size, pe);
        guard = 0;
        while (nlog < len && guard < 400) begin tick(); guard++; end
        ticks(2);
        chk(nlog == len, "R3", "write count", nlog, len);
        bad = 0;
        for (int i = 0; i < nlog && i < len; i++) begin
            logic [AW-1:0] ea;
            logic [7:0] ed;
            ea = addr + AW'(i);
            ed = (i < dr) ? fifo_mem[i] : s_mem[i - dr];
            if (log_a[i] != ea || log_d[i] != ed) begin
                if (bad == 0)
                    chk(0, (i < dr) ? "R3" : "R4", "write order addr/data",
                        {log_a[i], log_d[i]}, {ea, ed});
                bad++;
            end
        end
        if (bad == 0) chk(1, "R3", "write order", 0, 0);
        chk(cur_ptr == addr + AW'(len), "R11", "final pointer", cur_ptr, addr + AW'(len));
        chk(fcnt == k - dr, "R3", "bytes popped", k - fcnt, dr);
        chk(pend_size == 0 && done_irq == 1, "R8", "done at end", {pend_size, done_irq}, 1);
        s_n = pe + 2;
        ticks(4);
        chk(s_idx == pe && nlog == len, "R4", "live bytes refused when idle", s_idx, pe);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        cyc = 0; req_aw = 0; req_lw = 0; req_av = '0; req_lv = '0;
        prep(0, 0);
        ticks(3);
        rst_n = 1'b1;
        ticks(1);
        // R9 reset state
        chk(cur_ptr == 0, "R9", "reset pointer", cur_ptr, 0);
        chk(pend_size == 0, "R9", "reset pend", pend_size, 0);
        chk(mem_valid == 0, "R9", "reset mem_valid", mem_valid, 0);

        // R2 R3 R4 sweep over FIFO fill and length, two ready patterns
        for (int m = 0; m < 2; m++)
            for (int k = 0; k <= 6; k++)
                for (int l = 1; l <= 8; l++)
                    run_case(AW'(16'h1000 + k * 64 + l * 4), l, k, m);

        // R11 wrap
        run_case(16'hFFFE, 5, 2, 1);

        // R8 enable off
        irq_en = 1'b0; ticks(1);
        chk(done_irq == 0, "R8", "irq disabled", done_irq, 0);
        irq_en = 1'b1;

        // R5 R6 stall during drain, then late length write
        prep(4, 2);
        wr_addr(16'h0200);
        wr_len(8'd4);
        ticks(3);
        chk(mem_valid == 1 && mem_addr == 16'h0200, "R5", "stalled write held", mem_addr, 16'h0200);
        wr_len(8'd9);
        chk(pend_size == 0, "R6", "length during drain ignored", pend_size, 0);
        rdy_mode = 0;
        s_n = 8;
        ticks(12);
        chk(nlog == 4 && cur_ptr == 16'h0204, "R6", "only drain written", nlog, 4);
        chk(s_idx == 0, "R6", "no live bytes taken", s_idx, 0);

        // R1 cancel during streaming
        prep(0, 0);
        wr_addr(16'h0300);
        s_n = 3;
        wr_len(8'd10);
        ticks(6);
        chk(pend_size == 7 && done_irq == 0, "R8", "pending not done", pend_size, 7);
        wr_addr(16'h0500);
        chk(cur_ptr == 16'h0500 && pend_size == 0, "R1", "cancel streaming", pend_size, 0);
        s_n = 6;
        ticks(4);
        chk(nlog == 3 && s_idx == 3, "R1", "no writes after cancel", nlog, 3);

        // R1 cancel during a stalled drain
        prep(5, 2);
        wr_addr(16'h0600);
        wr_len(8'd5);
        ticks(2);
        wr_addr(16'h0680);
        rdy_mode = 0;
        ticks(5);
        chk(nlog == 0 && fcnt == 5, "R1", "drain stopped", nlog, 0);

        // R7 zero length
        prep(3, 0);
        wr_addr(16'h0700);
        wr_len(8'd0);
        ticks(3);
        chk(cur_ptr == 16'h0700 && pend_size == 0 && nlog == 0, "R7", "zero length", nlog, 0);

        // R10 same-cycle pointer and length writes
        prep(0, 0);
        s_n = 4;
        req_aw = 1; req_av = 16'h0800; req_lw = 1; req_lv = 8'd6;
        tick();
        ticks(3);
        chk(cur_ptr == 16'h0800 && pend_size == 0 && nlog == 0, "R10", "pointer wins", pend_size, 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule